// File: doc/BRIEF.md
# Memory Protection Region Matcher

This block checks every memory access against a table of eight programmable protection regions. Each region has a base address, a power-of-two size, an enable bit, an 8-bit subregion-disable mask, three permission bits and an 8-bit attribute byte. An access gives an address, a privilege flag and a kind (read, write or execute). The block finds which enabled region claims the address and applies that region's permissions. It returns the region's number and attributes, or a fault code.

A region of 256 bytes or more is split into eight equal subregions, and any of them can be switched off. An address in a switched-off subregion is not claimed by that region, so a lower-numbered region that overlaps it can take it instead. When several regions claim an address, the highest-numbered one wins. Software programs the table through a simple write port. One base-register write can select the target region and set its base in the same cycle. The result of a check is registered and appears one clock after the request.

Top module: `mpu_region_check`

## Requirements
- R1: After reset all regions are disabled, the unit is globally disabled, the selected region is 0, `rsp_valid` is 0 and `cfg_error` is all zeros.
- R2: A write to register 0 (`cfg_addr`=0) sets the base of a region from `cfg_wdata[31:5]`. If bit 4 of the word is set, bits [2:0] first become the selected region number and the base goes to that region. If bit 4 is clear, the base goes to the region already selected. Register 3 sets the selected region from bits [2:0].
- R3: Register 1 programs the selected region: bit 0 enable, bits [5:1] size code N, bits [15:8] subregion mask, bit 16 user access allowed, bit 17 write allowed, bit 18 execute-never, bits [31:24] attributes. A region covers 2^(N+1) bytes, and a code below 4 acts as 4. Base bits below the region size are ignored.
- R4: A region with N ≥ 7 has eight equal subregions. Mask bit 0 switches off the lowest-addressed one and bit 7 the highest.
- R5: A region does not claim an address in a switched-off subregion. Another enabled region covering that address may then claim it. For example, a 512 KB region with mask 0x03 lets a 128 KB region at the same base govern the first 128 KB.
- R6: With the unit enabled, an access that no region claims returns hit 0, region 0, fault code 1 and the default attributes.
- R7: A claimed access returns fault code 2 (permission) when it is unprivileged and the region disallows user access, when it is a write (kind 1) and writes are not allowed, or when it is an execute (kind 2) and the region is execute-never. Otherwise it returns fault code 0. Kind 0 is a read.
- R8: When several enabled regions claim an address, the highest-numbered region wins.
- R9: The response is valid one clock after a request is sampled, and `rsp_valid` is 0 in any cycle that follows a cycle with no request.
- R10: Register 2 bit 0 is the global enable. While it is 0, every access returns hit 0, region 0, fault code 0 and the default attributes.
- R11: `cfg_error[i]` is 1 exactly when region i is enabled, its size code gives fewer than 256 bytes, and its subregion mask is nonzero.
- R12: A claimed access returns hit 1, the winning region's number and that region's attribute byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 base, 1 region settings, 2 global control, 3 region select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_priv | input | 1 | Access is privileged |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Registered response valid |
| rsp_hit | output | 1 | A region claimed the access |
| rsp_region | output | 3 | Winning region number |
| rsp_fault | output | 2 | 0 none, 1 no region, 2 permission |
| rsp_attr | output | 8 | Attributes of the winning region, or the default |
| cfg_error | output | 8 | Per-region illegal subregion mask on a small region |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-response timing;
- that a globally disabled unit never reports a hit or a fault;
- that an access no region claims returns fault code 1;
- that the reported winner was claiming in the request cycle with no higher-numbered region also claiming.

Some behaviour only the bench's scenarios can show:
- the subregion fall-through to a lower region and the order of the mask bits;
- base alignment and the combined select-and-base write;
- which permission combinations cause a fault;
- the small-region configuration flag.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int ADDR_W    = 32;
    localparam int ATTR_W    = 8;
    localparam int SIZE_W    = 5;
    localparam int SRD_W     = 8;
    localparam int ALIGN_LSB = 5;   // smallest region is 32 bytes
    localparam int VALID_BIT = 4;   // base write also selects the region

    localparam logic [SIZE_W-1:0] SIZE_MIN     = SIZE_W'(4);  // 32 bytes
    localparam logic [SIZE_W-1:0] SIZE_SUB_MIN = SIZE_W'(7);  // 256 bytes

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NOREGION = 2'd1,
        FLT_PERM     = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } access_e;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_ATTR = 2'd1,
        CFG_CTRL = 2'd2,
        CFG_SEL  = 2'd3
    } cfg_reg_e;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [SRD_W-1:0]  srd;
        logic              user_ok;
        logic              write_ok;
        logic              xn;
        logic [ATTR_W-1:0] attr;
        logic [ADDR_W-1:0] base;
    } region_t;

endpackage

// File: rtl/mpu_region_regs.sv
module mpu_region_regs
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_addr,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output region_t [NUM_REGIONS-1:0]     regions,
    output logic                          glob_en
);

    typedef struct packed {
        region_t [NUM_REGIONS-1:0] rgn;
        logic                      glob_en;
        logic [IDX_W-1:0]          sel;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [IDX_W-1:0] num;
    logic [IDX_W-1:0] tgt;

    always_comb begin
        regs_d = regs_q;
        num    = cfg_wdata[IDX_W-1:0];
        tgt    = regs_q.sel;
        if (cfg_we) begin
            unique case (cfg_addr)
                CFG_BASE: begin
                    if (cfg_wdata[VALID_BIT]) begin
                        tgt        = num;
                        regs_d.sel = num;
                    end
                    regs_d.rgn[tgt].base = {cfg_wdata[ADDR_W-1:ALIGN_LSB], ALIGN_LSB'(0)};
                end
                CFG_ATTR: begin
                    regs_d.rgn[regs_q.sel].en       = cfg_wdata[0];
                    regs_d.rgn[regs_q.sel].size     = cfg_wdata[5:1];
                    regs_d.rgn[regs_q.sel].srd      = cfg_wdata[15:8];
                    regs_d.rgn[regs_q.sel].user_ok  = cfg_wdata[16];
                    regs_d.rgn[regs_q.sel].write_ok = cfg_wdata[17];
                    regs_d.rgn[regs_q.sel].xn       = cfg_wdata[18];
                    regs_d.rgn[regs_q.sel].attr     = cfg_wdata[31:24];
                end
                CFG_CTRL: regs_d.glob_en = cfg_wdata[0];
                CFG_SEL:  regs_d.sel     = num;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regions = regs_q.rgn;
    assign glob_en = regs_q.glob_en;

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
(
    input  region_t           rgn,
    input  logic [ADDR_W-1:0] addr,
    output logic              claim,
    output logic              cfg_err
);

    logic [SIZE_W-1:0] n;
    logic [SIZE_W:0]   shamt;
    logic [ADDR_W-1:0] diff;
    logic [2:0]        sub;
    logic              in_range;
    logic              has_sub;
    logic              sub_off;
    logic              unused_fields;

    always_comb begin
        n        = (rgn.size < SIZE_MIN) ? SIZE_MIN : rgn.size;
        shamt    = {1'b0, n} + 1'b1;
        diff     = addr ^ rgn.base;
        in_range = (diff >> shamt) == '0;
        has_sub  = (n >= SIZE_SUB_MIN);
        sub      = 3'(addr >> (n - SIZE_W'(2)));
        sub_off  = has_sub && rgn.srd[sub];
        claim    = rgn.en && in_range && !sub_off;
        cfg_err  = rgn.en && !has_sub && (rgn.srd != '0);
    end

    assign unused_fields = ^{rgn.user_ok, rgn.write_ok, rgn.xn, rgn.attr};

endmodule

// File: rtl/mpu_prio_select.sv
module mpu_prio_select #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] claim,
    output logic                   any,
    output logic [IDX_W-1:0]       win
);

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (claim[i]) begin
                any = 1'b1;
                win = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
    import mpu_pkg::*;
#(
    parameter int                NUM_REGIONS  = 8,
    parameter logic [ATTR_W-1:0] DEFAULT_ATTR = '0,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_addr,
    input  logic [ADDR_W-1:0]      cfg_wdata,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_priv,
    input  logic [1:0]             req_kind,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [IDX_W-1:0]       rsp_region,
    output logic [1:0]             rsp_fault,
    output logic [ATTR_W-1:0]      rsp_attr,
    output logic [NUM_REGIONS-1:0] cfg_error
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  region;
        fault_e            fault;
        logic [ATTR_W-1:0] attr;
    } res_t;

    region_t [NUM_REGIONS-1:0] regions_w;
    logic                      glob_en_w;
    logic [NUM_REGIONS-1:0]    claim_w;
    logic                      any_w;
    logic [IDX_W-1:0]          win_w;
    region_t                   win_rgn;
    logic                      perm_bad;
    res_t                      res_d, res_q;

    mpu_region_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .regions   (regions_w),
        .glob_en   (glob_en_w)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpu_region_match u_match (
            .rgn     (regions_w[g]),
            .addr    (req_addr),
            .claim   (claim_w[g]),
            .cfg_err (cfg_error[g])
        );
    end

    mpu_prio_select #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
        .claim (claim_w),
        .any   (any_w),
        .win   (win_w)
    );

    always_comb begin
        win_rgn  = regions_w[win_w];
        perm_bad = (!req_priv && !win_rgn.user_ok)
                || (req_kind == ACC_WRITE && !win_rgn.write_ok)
                || (req_kind == ACC_EXEC && win_rgn.xn);

        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            if (!glob_en_w) begin
                res_d.hit    = 1'b0;
                res_d.region = '0;
                res_d.fault  = FLT_NONE;
                res_d.attr   = DEFAULT_ATTR;
            end else if (!any_w) begin
                res_d.hit    = 1'b0;
                res_d.region = '0;
                res_d.fault  = FLT_NOREGION;
                res_d.attr   = DEFAULT_ATTR;
            end else begin
                res_d.hit    = 1'b1;
                res_d.region = win_w;
                res_d.fault  = perm_bad ? FLT_PERM : FLT_NONE;
                res_d.attr   = win_rgn.attr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rsp_valid  = res_q.valid;
    assign rsp_hit    = res_q.hit;
    assign rsp_region = res_q.region;
    assign rsp_fault  = res_q.fault;
    assign rsp_attr   = res_q.attr;

endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic [IDX_W-1:0]       rsp_region,
    input logic [1:0]             rsp_fault,
    input logic                   glob_en,
    input logic [NUM_REGIONS-1:0] claim_vec
);

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_disabled_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glob_en) |=> (!rsp_hit && rsp_fault == 2'd0));

    assert_unclaimed_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && glob_en && claim_vec == '0) |=> (!rsp_hit && rsp_fault == 2'd1));

    assert_winner_highest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && glob_en && claim_vec != '0) |=>
            (rsp_hit && (($past(claim_vec) >> rsp_region) == NUM_REGIONS'(1))));

    assert_fault_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));

endmodule

bind mpu_region_check mpu_region_check_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_region (rsp_region),
    .rsp_fault  (rsp_fault),
    .glob_en    (glob_en_w),
    .claim_vec  (claim_w)
);

// File: tb/mpu_region_check_test.sv
module mpu_region_check_test;

    localparam logic [7:0] DEF = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_priv = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_region;
    logic [1:0]  rsp_fault;
    logic [7:0]  rsp_attr;
    logic [7:0]  cfg_error;

    always #5 clk = ~clk;

    mpu_region_check #(.NUM_REGIONS(8), .DEFAULT_ATTR(DEF)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_priv(req_priv), .req_kind(req_kind), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_fault(rsp_fault),
        .rsp_attr(rsp_attr), .cfg_error(cfg_error)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // bench-side view of the programmed table, built from the register layout
    logic [31:0] m_base [8];
    logic        m_en   [8];
    logic [4:0]  m_size [8];
    logic [7:0]  m_srd  [8];
    logic        m_user [8];
    logic        m_wr   [8];
    logic        m_xn   [8];
    logic [7:0]  m_attr [8];
    logic [2:0]  m_sel = '0;
    logic        m_gen = 1'b0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        logic [2:0] tgt;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tgt = m_sel;
        case (a)
            2'd0: begin
                if (d[4]) begin tgt = d[2:0]; m_sel = d[2:0]; end
                m_base[tgt] = {d[31:5], 5'b0};
            end
            2'd1: begin
                m_en[m_sel] = d[0]; m_size[m_sel] = d[5:1]; m_srd[m_sel] = d[15:8];
                m_user[m_sel] = d[16]; m_wr[m_sel] = d[17]; m_xn[m_sel] = d[18];
                m_attr[m_sel] = d[31:24];
            end
            2'd2: m_gen = d[0];
            default: m_sel = d[2:0];
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_region(input logic [2:0] r, input logic [31:0] base, input logic en,
                              input logic [4:0] n, input logic [7:0] srd, input logic user,
                              input logic wr, input logic xn, input logic [7:0] attr,
                              input logic use_valid);
        if (use_valid) begin
            cfg_write(2'd0, {base[31:5], 1'b1, 1'b0, r});
        end else begin
            cfg_write(2'd3, {29'd0, r});
            cfg_write(2'd0, {base[31:5], 5'b0});
        end
        cfg_write(2'd1, {attr, 5'b0, xn, wr, user, srd, 2'b0, n, en});
    endtask

    // expected {hit, region, fault, attr} from the requirements
    function automatic logic [13:0] model(input logic [31:0] addr, input logic priv,
                                          input logic [1:0] kind);
        logic found = 1'b0;
        int   w = 0;
        longint unsigned sz, lo, a;
        int   n, idx;
        logic bad;
        if (!m_gen) return {1'b0, 3'd0, 2'd0, DEF};
        a = {32'd0, addr};
        for (int r = 0; r < 8; r++) begin
            if (m_en[r]) begin
                n  = (m_size[r] < 5'd4) ? 4 : int'(m_size[r]);
                sz = 64'd1 << (n + 1);
                lo = {32'd0, m_base[r]} & ~(sz - 64'd1);
                if (a >= lo && a < lo + sz) begin
                    idx = int'((a - lo) / (sz / 64'd8));
                    if (!(n >= 7 && m_srd[r][idx])) begin
                        found = 1'b1;
                        w = r;
                    end
                end
            end
        end
        if (!found) return {1'b0, 3'd0, 2'd1, DEF};
        bad = (!priv && !m_user[w]) || (kind == 2'd1 && !m_wr[w]) || (kind == 2'd2 && m_xn[w]);
        return {1'b1, 3'(w), bad ? 2'd2 : 2'd0, m_attr[w]};
    endfunction

    task automatic access(input logic [31:0] addr, input logic priv, input logic [1:0] kind,
                          output logic [13:0] got);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_priv = priv; req_kind = kind;
        @(negedge clk);
        got = {rsp_hit, rsp_region, rsp_fault, rsp_attr};
        chk("R9 response valid one cycle after request", {31'd0, rsp_valid}, 32'd1);
        req_valid = 1'b0;
    endtask

    task automatic acc_exp(input string req, input logic [31:0] addr, input logic priv,
                           input logic [1:0] kind, input logic hit, input logic [2:0] rg,
                           input logic [1:0] flt, input logic [7:0] attr);
        logic [13:0] got;
        access(addr, priv, kind, got);
        chk(req, {18'd0, got}, {18'd0, hit, rg, flt, attr});
    endtask

    task automatic acc_model(input logic [31:0] addr, input logic priv, input logic [1:0] kind);
        logic [13:0] got;
        logic [13:0] exp;
        exp = model(addr, priv, kind);
        access(addr, priv, kind, got);
        chk("R3 R4 R5 R6 R7 R8 R12 random access", {18'd0, got}, {18'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681357));
        for (int r = 0; r < 8; r++) begin
            m_base[r] = '0; m_en[r] = 1'b0; m_size[r] = '0; m_srd[r] = '0;
            m_user[r] = 1'b0; m_wr[r] = 1'b0; m_xn[r] = 1'b0; m_attr[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 cfg_error after reset", {24'd0, cfg_error}, 32'd0);
        acc_exp("R1 R10 globally disabled after reset", 32'h1234, 1'b0, 2'd1, 1'b0, 3'd0, 2'd0, DEF);

        // R6 enabled, no regions
        cfg_write(2'd2, 32'd1);
        acc_exp("R6 no region claims", 32'h1234, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);

        // R2 combined select-and-base write, R12 attributes
        set_region(3'd2, 32'h1000, 1'b1, 5'd11, 8'h00, 1'b1, 1'b1, 1'b0, 8'hA2, 1'b1);
        acc_exp("R2 R12 base with select", 32'h1800, 1'b1, 2'd0, 1'b1, 3'd2, 2'd0, 8'hA2);
        cfg_write(2'd0, 32'h0000_8000);
        acc_exp("R2 base without select, old range", 32'h1800, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);
        acc_exp("R2 base without select, new range", 32'h8010, 1'b1, 2'd0, 1'b1, 3'd2, 2'd0, 8'hA2);

        // R3 low base bits ignored
        cfg_write(2'd0, 32'h0000_8C20);
        acc_exp("R3 aligned start", 32'h8000, 1'b1, 2'd0, 1'b1, 3'd2, 2'd0, 8'hA2);
        acc_exp("R3 last byte", 32'h8FFF, 1'b1, 2'd0, 1'b1, 3'd2, 2'd0, 8'hA2);
        acc_exp("R3 past end", 32'h9000, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);
        acc_exp("R3 before start", 32'h7FFF, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);
        cfg_write(2'd1, 32'd0);

        // R5 128 KB under 512 KB with mask 0x03
        set_region(3'd1, 32'h0, 1'b1, 5'd16, 8'h00, 1'b1, 1'b1, 1'b0, 8'h11, 1'b1);
        set_region(3'd3, 32'h0, 1'b1, 5'd18, 8'h03, 1'b1, 1'b1, 1'b0, 8'h33, 1'b0);
        acc_exp("R5 low part to small region", 32'h0100, 1'b1, 2'd0, 1'b1, 3'd1, 2'd0, 8'h11);
        acc_exp("R5 end of small region", 32'h1FFFF, 1'b1, 2'd0, 1'b1, 3'd1, 2'd0, 8'h11);
        acc_exp("R5 large region resumes", 32'h20000, 1'b1, 2'd0, 1'b1, 3'd3, 2'd0, 8'h33);
        acc_exp("R5 large region top", 32'h7FFFF, 1'b1, 2'd0, 1'b1, 3'd3, 2'd0, 8'h33);
        acc_exp("R5 beyond both", 32'h80000, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);

        // R4 mask bit order
        set_region(3'd1, 32'h0, 1'b0, 5'd16, 8'h00, 1'b1, 1'b1, 1'b0, 8'h11, 1'b1);
        set_region(3'd3, 32'h0, 1'b1, 5'd18, 8'h80, 1'b1, 1'b1, 1'b0, 8'h33, 1'b1);
        acc_exp("R4 bit 7 is top subregion", 32'h70000, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);
        acc_exp("R4 below top subregion", 32'h6FFFF, 1'b1, 2'd0, 1'b1, 3'd3, 2'd0, 8'h33);
        acc_exp("R4 bottom kept", 32'h0, 1'b1, 2'd0, 1'b1, 3'd3, 2'd0, 8'h33);
        set_region(3'd3, 32'h0, 1'b1, 5'd18, 8'h01, 1'b1, 1'b1, 1'b0, 8'h33, 1'b1);
        acc_exp("R4 bit 0 is bottom subregion", 32'hFFFF, 1'b1, 2'd0, 1'b0, 3'd0, 2'd1, DEF);
        acc_exp("R4 second subregion kept", 32'h10000, 1'b1, 2'd0, 1'b1, 3'd3, 2'd0, 8'h33);

        // R8 priority
        set_region(3'd3, 32'h0, 1'b1, 5'd18, 8'h00, 1'b1, 1'b1, 1'b0, 8'h33, 1'b1);
        set_region(3'd5, 32'h0, 1'b1, 5'd7, 8'h00, 1'b1, 1'b1, 1'b0, 8'h55, 1'b1);
        acc_exp("R8 higher number wins", 32'h10, 1'b1, 2'd0, 1'b1, 3'd5, 2'd0, 8'h55);
        acc_exp("R8 outside higher region", 32'h100, 1'b1, 2'd0, 1'b1, 3'd3, 2'd0, 8'h33);

        // R7 permissions
        set_region(3'd6, 32'h40000, 1'b1, 5'd9, 8'h00, 1'b0, 1'b0, 1'b1, 8'h66, 1'b1);
        acc_exp("R7 privileged read allowed", 32'h40010, 1'b1, 2'd0, 1'b1, 3'd6, 2'd0, 8'h66);
        acc_exp("R7 user read denied", 32'h40010, 1'b0, 2'd0, 1'b1, 3'd6, 2'd2, 8'h66);
        acc_exp("R7 write denied", 32'h40010, 1'b1, 2'd1, 1'b1, 3'd6, 2'd2, 8'h66);
        acc_exp("R7 execute-never", 32'h40010, 1'b1, 2'd2, 1'b1, 3'd6, 2'd2, 8'h66);
        acc_exp("R7 user execute allowed", 32'h50000, 1'b0, 2'd2, 1'b1, 3'd3, 2'd0, 8'h33);

        // R9 idle after request
        @(negedge clk);
        chk("R9 idle cycle", {31'd0, rsp_valid}, 32'd0);

        // R11 small region mask flag
        set_region(3'd4, 32'h90000, 1'b1, 5'd5, 8'h01, 1'b1, 1'b1, 1'b0, 8'h44, 1'b1);
        chk("R11 small region with mask", {24'd0, cfg_error}, 32'h10);
        set_region(3'd4, 32'h90000, 1'b1, 5'd7, 8'h01, 1'b1, 1'b1, 1'b0, 8'h44, 1'b1);
        chk("R11 256-byte region with mask", {24'd0, cfg_error}, 32'h00);
        set_region(3'd4, 32'h90000, 1'b0, 5'd5, 8'h01, 1'b1, 1'b1, 1'b0, 8'h44, 1'b1);
        chk("R11 disabled small region", {24'd0, cfg_error}, 32'h00);

        // R10 global disable
        cfg_write(2'd2, 32'd0);
        acc_exp("R10 disabled passes", 32'h40010, 1'b0, 2'd1, 1'b0, 3'd0, 2'd0, DEF);
        cfg_write(2'd2, 32'd1);

        // random configurations
        for (int c = 0; c < 30; c++) begin
            for (int r = 0; r < 8; r++) begin
                logic [4:0] n;
                n = 5'(4 + ($urandom % 10));
                set_region(3'(r), $urandom & 32'h0001_FFE0, ($urandom % 4) != 0, n,
                           (n >= 5'd7) ? 8'($urandom) : 8'h00, 1'($urandom), 1'($urandom),
                           1'($urandom), 8'($urandom), 1'($urandom));
            end
            cfg_write(2'd2, (c % 7 == 6) ? 32'd0 : 32'd1);
            for (int k = 0; k < 25; k++) begin
                acc_model(($urandom % 8 != 0) ? ($urandom & 32'h0001_FFFF) : $urandom,
                          1'($urandom), 2'($urandom % 3));
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule